// File: doc/BRIEF.md
# Nested Exception Priority Arbiter

This block decides which exception the processor core takes next. Its requests come from three groups. Three system exceptions have fixed priorities that no configurable level can beat. Two system exceptions and nine level-sensitive peripheral interrupt lines take a 2-bit priority level, which software sets through a small register port. The arbiter ranks all pending requests. Among requests of equal priority, the lowest exception number wins. The best request is taken only if it is strictly more urgent than the exception that is running now.

Every exception that is taken is pushed onto an internal stack of active exceptions, which holds at most four entries. When the core signals that a handler has returned, the top entry is popped. The previous running exception and its priority come back, and the pending requests are arbitrated again against that restored level. The core says when it can accept an exception. The arbiter answers with a one-cycle take strobe and the exception number to enter.

Top module: `excarb_top`

## Requirements
- R1: Exception numbers 1, 2 and 3 (request bits 0, 1 and 2 of `fixedReq`) have fixed priorities -3, -2 and -1. Any of them beats every configurable level.
- R2: A numerically lower priority wins. If several pending requests share the best priority, the lowest exception number is taken.
- R3: A pending request is taken only if its priority is strictly lower in number than the running priority. A request with the same priority as the running exception does not preempt it.
- R4: When no exception is active, the running priority is below level 3, so any pending request is taken. In that state `curNum` reads 0 and `nestDepth` reads 0.
- R5: Interrupt line k maps to exception number 16+k. The line is level-sensitive: while it stays high after its handler returns, it is taken again.
- R6: Register word k/4 (`regAddr` 0 to 3) holds the level of interrupt k in bits [8*(k%4)+7 : 8*(k%4)+6]. Word 4 holds the levels of exception 14 in bits [23:22] and exception 15 in bits [31:30]. All other bits and addresses read as zero, and writes to them have no effect.
- R7: At most four exceptions are active at once. With four active, no request is taken, including one with a fixed priority.
- R8: A return pops the stack and restores the previous `curNum`. Pending requests are then judged against the restored priority. In a cycle with a return, no exception is taken.
- R9: An exception is taken only in a cycle where `coreAccept` is high. `takeStb` is then high for exactly one cycle, starting after that clock edge. In the same cycle `takeNum` and `curNum` show the exception number and `nestDepth` has risen by one.
- R10: After reset, no exception is active, `takeStb` is low, and all priority levels read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLine | input | NUM_IRQ | Level-sensitive peripheral interrupt lines, exception 16+k |
| fixedReq | input | 3 | Requests for exceptions 1, 2 and 3 |
| sysReq | input | 2 | Requests for exceptions 14 (bit 0) and 15 (bit 1) |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| coreAccept | input | 1 | The core can enter an exception this cycle |
| excReturn | input | 1 | The current handler has returned |
| takeStb | output | 1 | One-cycle pulse: an exception was taken |
| takeNum | output | 5 | Number of the exception last taken |
| curNum | output | 5 | Number of the running exception, 0 when idle |
| nestDepth | output | $clog2(NEST_DEPTH+1) | Number of active exceptions |

## Verification
A take and a return each show their result one clock edge after the cycle that caused them. In that cycle `takeStb`, `takeNum`, `curNum` and `nestDepth` all change together. Register reads are combinational, and a write is visible in the cycle after its edge. The bench drives inputs 1 ns after a rising edge, lets exactly one edge pass, and samples 1 ns after it. Every check therefore looks at the first cycle in which a result is due, and no check waits loosely for a result to appear. The arbitration sweep covers every pair of interrupt lines with every pair of levels. A second sweep covers every combination of running level and incoming level.

// File: rtl/excarb_pkg.sv
package excarb_pkg;
  localparam int EXC_W   = 5;
  localparam int NUM_EXC = 1 << EXC_W;
  localparam int RANK_W  = 3;
  localparam int LVL_W   = 2;

  typedef logic [EXC_W-1:0]  excNum_t;
  typedef logic [RANK_W-1:0] rank_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  // Internal rank: 0..2 stand for the fixed priorities -3..-1,
  // 3..6 for configurable levels 0..3, 7 for "nothing running".
  localparam rank_t RANK_IDLE     = rank_t'(7);
  localparam rank_t RANK_CFG_BASE = rank_t'(3);

  localparam excNum_t EXC_FIXED_BASE = excNum_t'(1);
  localparam excNum_t EXC_SYS_A      = excNum_t'(14);
  localparam excNum_t EXC_SYS_B      = excNum_t'(15);
  localparam excNum_t EXC_IRQ_BASE   = excNum_t'(16);

  typedef struct packed {
    logic push;
    logic pop;
  } arbCtl_t;

  function automatic rank_t cfgRank(input lvl_t lvl);
    return RANK_CFG_BASE + rank_t'(lvl);
  endfunction
endpackage

// File: rtl/excarb_datapath.sv
module excarb_datapath
  import excarb_pkg::*;
#(
  parameter int NUM_IRQ    = 9,
  parameter int NEST_DEPTH = 4,
  parameter int DEPTH_W    = $clog2(NEST_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqLine,
  input  logic [2:0]         fixedReq,
  input  logic [1:0]         sysReq,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  arbCtl_t            ctl,
  output logic               bestValid,
  output rank_t              bestRank,
  output rank_t              runRank,
  output logic [DEPTH_W-1:0] depth,
  output logic               takeStb,
  output excNum_t            takeNum,
  output excNum_t            curNum
);
  localparam int IDX_W = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;
  localparam logic [2:0] SYS_ADDR = 3'd4;

  lvl_t    irqLvl [NUM_IRQ];
  lvl_t    sysLvl [2];
  excNum_t stkNum [NEST_DEPTH];
  rank_t   stkRank[NEST_DEPTH];

  logic [NUM_EXC-1:0] reqVec;
  logic [NUM_EXC-1:0] activeMask;
  rank_t              rankArr[NUM_EXC];
  excNum_t            bestNum;
  logic [IDX_W-1:0]   topIdx;
  logic [IDX_W-1:0]   pushIdx;

  // Priority level storage; one generate branch per interrupt line.
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irqLvl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqLvl[k] <= '0;
      else if (regWe && regAddr == 3'(k / 4))
        irqLvl[k] <= regWdata[8 * (k % 4) + 6 +: LVL_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysLvl[0] <= '0;
      sysLvl[1] <= '0;
    end else if (regWe && regAddr == SYS_ADDR) begin
      sysLvl[0] <= regWdata[23:22];
      sysLvl[1] <= regWdata[31:30];
    end
  end

  always_comb begin
    regRdata = '0;
    for (int k = 0; k < NUM_IRQ; k++)
      if (regAddr == 3'(k / 4)) regRdata[8 * (k % 4) + 6 +: LVL_W] = irqLvl[k];
    if (regAddr == SYS_ADDR) begin
      regRdata[23:22] = sysLvl[0];
      regRdata[31:30] = sysLvl[1];
    end
  end

  // Request and rank tables indexed by exception number.
  always_comb begin
    reqVec = '0;
    for (int e = 0; e < NUM_EXC; e++) rankArr[e] = RANK_IDLE;
    for (int f = 0; f < 3; f++) begin
      reqVec[int'(EXC_FIXED_BASE) + f]  = fixedReq[f];
      rankArr[int'(EXC_FIXED_BASE) + f] = rank_t'(f);
    end
    reqVec[EXC_SYS_A]  = sysReq[0];
    rankArr[EXC_SYS_A] = cfgRank(sysLvl[0]);
    reqVec[EXC_SYS_B]  = sysReq[1];
    rankArr[EXC_SYS_B] = cfgRank(sysLvl[1]);
    for (int k = 0; k < NUM_IRQ; k++) begin
      reqVec[int'(EXC_IRQ_BASE) + k]  = irqLine[k];
      rankArr[int'(EXC_IRQ_BASE) + k] = cfgRank(irqLvl[k]);
    end
  end

  always_comb begin
    activeMask = '0;
    for (int s = 0; s < NEST_DEPTH; s++)
      if (DEPTH_W'(s) < depth) activeMask[stkNum[s]] = 1'b1;
  end

  // Ascending scan with strict compare: lowest number wins a tie.
  always_comb begin
    bestValid = 1'b0;
    bestRank  = RANK_IDLE;
    bestNum   = '0;
    for (int e = 0; e < NUM_EXC; e++) begin
      if (reqVec[e] && !activeMask[e] && (!bestValid || rankArr[e] < bestRank)) begin
        bestValid = 1'b1;
        bestRank  = rankArr[e];
        bestNum   = excNum_t'(e);
      end
    end
  end

  assign topIdx  = IDX_W'(depth - DEPTH_W'(1));
  assign pushIdx = IDX_W'(depth);
  assign runRank = (depth == '0) ? RANK_IDLE : stkRank[topIdx];
  assign curNum  = (depth == '0) ? excNum_t'(0) : stkNum[topIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth   <= '0;
      takeStb <= 1'b0;
      takeNum <= '0;
      for (int s = 0; s < NEST_DEPTH; s++) begin
        stkNum[s]  <= '0;
        stkRank[s] <= RANK_IDLE;
      end
    end else begin
      takeStb <= ctl.push;
      if (ctl.push) begin
        stkNum[pushIdx]  <= bestNum;
        stkRank[pushIdx] <= bestRank;
        depth            <= depth + DEPTH_W'(1);
        takeNum          <= bestNum;
      end else if (ctl.pop) begin
        depth <= depth - DEPTH_W'(1);
      end
    end
  end
endmodule

// File: rtl/excarb_ctrl.sv
module excarb_ctrl
  import excarb_pkg::*;
#(
  parameter int NEST_DEPTH = 4,
  parameter int DEPTH_W    = $clog2(NEST_DEPTH + 1)
) (
  input  logic               coreAccept,
  input  logic               excReturn,
  input  logic               bestValid,
  input  rank_t              bestRank,
  input  rank_t              runRank,
  input  logic [DEPTH_W-1:0] depth,
  output arbCtl_t            ctl
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(NEST_DEPTH);

  logic roomLeft;
  logic urgent;

  assign roomLeft = depth < DEPTH_MAX;
  assign urgent   = bestValid && (bestRank < runRank);

  // A return owns its cycle; taking waits for the restored level.
  always_comb begin
    ctl.pop  = excReturn && (depth != '0);
    ctl.push = !excReturn && coreAccept && roomLeft && urgent;
  end
endmodule

// File: rtl/excarb_top.sv
module excarb_top
  import excarb_pkg::*;
#(
  parameter int NUM_IRQ    = 9,
  parameter int NEST_DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_IRQ-1:0]                irqLine,
  input  logic [2:0]                        fixedReq,
  input  logic [1:0]                        sysReq,
  input  logic                              regWe,
  input  logic [2:0]                        regAddr,
  input  logic [31:0]                       regWdata,
  output logic [31:0]                       regRdata,
  input  logic                              coreAccept,
  input  logic                              excReturn,
  output logic                              takeStb,
  output logic [4:0]                        takeNum,
  output logic [4:0]                        curNum,
  output logic [$clog2(NEST_DEPTH+1)-1:0]   nestDepth
);
  localparam int DEPTH_W = $clog2(NEST_DEPTH + 1);

  arbCtl_t ctl;
  logic    bestValid;
  rank_t   bestRank;
  rank_t   runRank;

  excarb_datapath #(.NUM_IRQ(NUM_IRQ), .NEST_DEPTH(NEST_DEPTH), .DEPTH_W(DEPTH_W)) dp_i (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .fixedReq(fixedReq), .sysReq(sysReq),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .ctl(ctl), .bestValid(bestValid), .bestRank(bestRank), .runRank(runRank),
    .depth(nestDepth), .takeStb(takeStb), .takeNum(takeNum), .curNum(curNum)
  );

  excarb_ctrl #(.NEST_DEPTH(NEST_DEPTH), .DEPTH_W(DEPTH_W)) ctrl_i (
    .coreAccept(coreAccept), .excReturn(excReturn), .bestValid(bestValid),
    .bestRank(bestRank), .runRank(runRank), .depth(nestDepth), .ctl(ctl)
  );
endmodule

// File: rtl/excarb_chk.sv
module excarb_chk #(
  parameter int NEST_DEPTH = 4,
  parameter int DEPTH_W    = $clog2(NEST_DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               coreAccept,
  input logic               excReturn,
  input logic               takeStb,
  input logic [4:0]         takeNum,
  input logic [4:0]         curNum,
  input logic [DEPTH_W-1:0] nestDepth
);
  // R7
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    nestDepth <= DEPTH_W'(NEST_DEPTH));

  // R7
  full_no_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    nestDepth == DEPTH_W'(NEST_DEPTH) |=> !takeStb);

  // R9
  take_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStb |-> nestDepth == $past(nestDepth) + DEPTH_W'(1));

  // R9
  take_cur_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStb |-> curNum == takeNum);

  // R9
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !coreAccept |=> !takeStb);

  // R8
  return_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReturn |=> !takeStb);

  // R8
  return_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReturn && nestDepth != '0 |=> nestDepth == $past(nestDepth) - DEPTH_W'(1));

  // R4
  idle_cur_chk: assert property (@(posedge clk) disable iff (!rstN)
    nestDepth == '0 |-> curNum == 5'd0);
endmodule

bind excarb_top excarb_chk #(.NEST_DEPTH(NEST_DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .coreAccept(coreAccept), .excReturn(excReturn),
  .takeStb(takeStb), .takeNum(takeNum), .curNum(curNum), .nestDepth(nestDepth)
);

// File: tb/excarb_top_tb_top.sv
module excarb_top_tb_top;
  localparam int NIRQ = 9;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NIRQ-1:0] irqLine = '0;
  logic [2:0]      fixedReq = '0;
  logic [1:0]      sysReq = '0;
  logic            regWe = 1'b0;
  logic [2:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic            coreAccept = 1'b0;
  logic            excReturn = 1'b0;
  logic            takeStb;
  logic [4:0]      takeNum;
  logic [4:0]      curNum;
  logic [2:0]      nestDepth;

  int checks = 0;
  int errors = 0;
  int mIrq[NIRQ];
  int mSys[2];

  always #10 clk = ~clk;

  excarb_top #(.NUM_IRQ(NIRQ), .NEST_DEPTH(4)) dut_i (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .fixedReq(fixedReq), .sysReq(sysReq),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .coreAccept(coreAccept), .excReturn(excReturn), .takeStb(takeStb),
    .takeNum(takeNum), .curNum(curNum), .nestDepth(nestDepth)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wordOf(input int a);
    logic [31:0] w = '0;
    for (int k = 0; k < NIRQ; k++)
      if (k / 4 == a) w[8 * (k % 4) + 6 +: 2] = 2'(mIrq[k]);
    if (a == 4) begin
      w[23:22] = 2'(mSys[0]);
      w[31:30] = 2'(mSys[1]);
    end
    return w;
  endfunction

  task automatic regWrite(input int a, input logic [31:0] d);
    regWe = 1'b1; regAddr = 3'(a); regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  task automatic pushLevels();
    for (int a = 0; a < 5; a++) regWrite(a, wordOf(a));
  endtask

  task automatic accept1();
    coreAccept = 1'b1;
    tick();
    coreAccept = 1'b0;
  endtask

  task automatic ret1();
    excReturn = 1'b1;
    tick();
    excReturn = 1'b0;
  endtask

  task automatic drain();
    irqLine = '0; fixedReq = '0; sysReq = '0;
    for (int n = 0; n < 5; n++) if (nestDepth != 0) ret1();
  endtask

  task automatic expTake(input string req, input int num, input int dep);
    chk(takeStb === 1'b1, req, int'(takeStb), 1);
    chk(takeNum == 5'(num) && curNum == 5'(num), req, int'(takeNum), num);
    chk(nestDepth == 3'(dep), req, int'(nestDepth), dep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NIRQ; k++) mIrq[k] = 0;
    mSys[0] = 0; mSys[1] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();

    // R10 reset state
    chk(nestDepth == 0 && curNum == 0, "R10", int'(nestDepth), 0);
    chk(takeStb == 1'b0, "R10", int'(takeStb), 0);
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a); #1;
      chk(regRdata == 32'h0, "R10", int'(regRdata), 0);
    end

    // R6 register map: all-ones writes land only in level fields
    for (int a = 0; a < 8; a++) regWrite(a, 32'hFFFF_FFFF);
    for (int k = 0; k < NIRQ; k++) mIrq[k] = 3;
    mSys[0] = 3; mSys[1] = 3;
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a); #1;
      chk(regRdata == wordOf(a), "R6", int'(regRdata), int'(wordOf(a)));
    end
    for (int k = 0; k < NIRQ; k++) mIrq[k] = (k * 3 + 1) % 4;
    mSys[0] = 2; mSys[1] = 1;
    pushLevels();
    for (int a = 0; a < 5; a++) begin
      regAddr = 3'(a); #1;
      chk(regRdata == wordOf(a), "R6", int'(regRdata), int'(wordOf(a)));
    end

    // R4 idle takes even the lowest level; R9 accept gating and one-cycle strobe
    mIrq[4] = 3; pushLevels();
    irqLine[4] = 1'b1;
    repeat (3) tick();
    chk(takeStb == 1'b0 && nestDepth == 0, "R9", int'(nestDepth), 0);
    coreAccept = 1'b1;
    tick();
    expTake("R4", 20, 1);
    tick();
    coreAccept = 1'b0;
    chk(takeStb == 1'b0 && nestDepth == 1, "R9", int'(takeStb), 0);
    drain();

    // R2 exhaustive pairs of lines and levels; R5 numbering
    for (int i = 0; i < NIRQ; i++)
      for (int j = i + 1; j < NIRQ; j++)
        for (int li = 0; li < 4; li++)
          for (int lj = 0; lj < 4; lj++) begin
            int win;
            mIrq[i] = li; mIrq[j] = lj;
            regWrite(i / 4, wordOf(i / 4));
            regWrite(j / 4, wordOf(j / 4));
            irqLine = '0; irqLine[i] = 1'b1; irqLine[j] = 1'b1;
            win = (lj < li) ? j : i;
            accept1();
            expTake("R2", 16 + win, 1);
            drain();
            chk(nestDepth == 0, "R8", int'(nestDepth), 0);
          end

    // R3 running level versus incoming level, strict compare only
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        mIrq[0] = a; mIrq[1] = b; pushLevels();
        irqLine = 9'b1;
        accept1();
        expTake("R3", 16, 1);
        irqLine[1] = 1'b1;
        accept1();
        if (b < a) expTake("R3", 17, 2);
        else chk(takeStb == 1'b0 && curNum == 16 && nestDepth == 1, "R3",
                 int'(curNum), 16);
        drain();
      end

    // R1 fixed priorities beat configurable level 0
    for (int k = 0; k < NIRQ; k++) mIrq[k] = 0;
    mSys[0] = 0; mSys[1] = 0; pushLevels();
    irqLine = 9'b1; sysReq = 2'b11; fixedReq = 3'b100;
    accept1();
    expTake("R1", 3, 1);
    fixedReq[1] = 1'b1;
    accept1();
    expTake("R1", 2, 2);
    fixedReq[0] = 1'b1;
    accept1();
    expTake("R1", 1, 3);
    irqLine = '0; sysReq = '0; fixedReq = '0;
    // R8 restore order on pops
    ret1();
    chk(curNum == 2 && nestDepth == 2, "R8", int'(curNum), 2);
    ret1();
    chk(curNum == 3 && nestDepth == 1, "R8", int'(curNum), 3);
    ret1();
    chk(curNum == 0 && nestDepth == 0, "R8", int'(curNum), 0);

    // R2 tie among system exceptions and a line: lowest number first
    mSys[0] = 1; mSys[1] = 1; mIrq[0] = 1; pushLevels();
    irqLine = 9'b1; sysReq = 2'b11;
    accept1();
    expTake("R2", 14, 1);
    drain();
    mSys[1] = 0; pushLevels();
    irqLine = 9'b1; sysReq = 2'b11;
    accept1();
    expTake("R2", 15, 1);
    drain();

    // R7 nesting cap at four, even for a fixed-priority request
    mIrq[3] = 3; mIrq[2] = 2; mIrq[1] = 1; mIrq[0] = 0; pushLevels();
    for (int n = 0; n < 4; n++) begin
      irqLine[3 - n] = 1'b1;
      accept1();
      expTake("R7", 19 - n, n + 1);
    end
    fixedReq[1] = 1'b1;
    accept1();
    chk(takeStb == 1'b0 && nestDepth == 4 && curNum == 16, "R7", int'(nestDepth), 4);
    irqLine = '0;
    ret1();
    chk(curNum == 17 && nestDepth == 3, "R8", int'(curNum), 17);
    accept1();
    expTake("R7", 2, 4);
    fixedReq = '0;
    ret1();
    chk(curNum == 17, "R8", int'(curNum), 17);
    ret1();
    chk(curNum == 18, "R8", int'(curNum), 18);
    ret1();
    chk(curNum == 19, "R8", int'(curNum), 19);
    ret1();
    chk(curNum == 0 && nestDepth == 0, "R8", int'(curNum), 0);

    // R5 level line retriggers after return; R8 return blocks take in its cycle
    mIrq[5] = 2; pushLevels();
    irqLine[5] = 1'b1;
    accept1();
    expTake("R5", 21, 1);
    excReturn = 1'b1; coreAccept = 1'b1;
    tick();
    excReturn = 1'b0;
    chk(takeStb == 1'b0 && nestDepth == 0, "R8", int'(takeStb), 0);
    tick();
    coreAccept = 1'b0;
    expTake("R5", 21, 1);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule